// File: doc/BRIEF.md
# Ring Interrupt Status Unit

This unit gathers the event pulses of one descriptor ring into a sticky status register and raises a level interrupt towards the host. Each event class has a fixed bit in a 32-bit word. A status-enable mask decides which events are recorded at all. A separate signal-enable mask decides which recorded bits may drive the interrupt line.

Software reads the status word and acknowledges the bits it has handled by writing the same value back. Each 1 written clears its bit. A force register lets a test inject any event class through the same path the hardware events take. All registers sit behind a plain address, write-data and write-strobe port with a combinational read-data output.

Top module: `ring_irq_unit`

## Requirements
- R1: After reset, status, status enable and signal enable read 0 and `irq_o` is low.
- R2: An event pulse on `evt_i[k]` whose status-enable bit is 1 sets its status bit on the next clock edge. The event index maps to status bit positions as follows: k=0 to bit 5 (transfer abort), k=1 to bit 6 (status-ring full), k=2 to bit 7 (stop-insertion warning), k=3 to bit 9 (transfer error), k=4 to bit 10 (ring operation done), k=5 to bit 11 (transfer complete) and k=6 to bit 12 (status entry ready).
- R3: An event whose status-enable bit is 0 leaves its status bit unchanged.
- R4: A write to the status register at offset 0x10 clears exactly the status bits that are 1 in the written value. All other status bits are kept.
- R5: An event that is recorded in the same cycle as a write that clears its bit leaves that bit set.
- R6: `irq_o` is high exactly while some status bit and its signal-enable bit (offset 0x18) are both 1. `irq_o` is a level and stays high until the bit is cleared or masked.
- R7: Writing 1s to the force register at offset 0x1C sets the matching status bits, gated by status enable, exactly as events do. The force register reads as 0.
- R8: Bit positions 0-4, 8 and 13-31 read as 0 in every register and ignore writes. Reads of any address other than 0x10, 0x14, 0x18 and 0x1C return 0. Writes to those other addresses change nothing.
- R9: Status enable (offset 0x14) and signal enable (offset 0x18) read back the last value written to them, limited to the seven event bits.
- R10: Clearing a status-enable bit keeps a status bit that is already latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Single-cycle event pulses, index mapped as in R2 |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong status bit becomes visible at the status read port one clock after the event or write that caused it. If that bit is signal-enabled, `irq_o` shows the error in the same cycle. A lost set/clear priority appears as a missing bit right after the colliding cycle. A wrong bit map shows up as a value at an unexpected position, and the sweep over every event pattern exposes it at once. Gating faults in either mask show up as bits or interrupts that appear while their enable is 0.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_EVT = 7;

  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_STAT_EN = 8'h14;
  localparam logic [7:0] OFF_SIG_EN = 8'h18;
  localparam logic [7:0] OFF_FORCE = 8'h1C;

  // Status bit position of event index k (software decodes these positions).
  function automatic int evt_bit(input int k);
    case (k)
      0: return 5;
      1: return 6;
      2: return 7;
      3: return 9;
      4: return 10;
      5: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] valid_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EVT; k++) m[evt_bit(k)] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic stat;
    logic sten;
    logic sgen;
    logic frc;
  } wr_sel_t;
endpackage

// File: rtl/ring_irq_evt_map.sv
module ring_irq_evt_map
  import ring_irq_pkg::*;
#(
  parameter int NEVT = NUM_EVT,
  parameter int DW   = DATA_W
) (
  input  logic [NEVT-1:0] evt_i,
  output logic [DW-1:0]   evt_word
);
  always_comb begin
    evt_word = '0;
    for (int k = 0; k < NEVT; k++) evt_word[evt_bit(k)] = evt_i[k];
  end
endmodule

// File: rtl/ring_irq_decode.sv
module ring_irq_decode
  import ring_irq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  output wr_sel_t       wsel,
  output wr_sel_t       rsel
);
  always_comb begin
    rsel.stat = (bus_addr == AW'(OFF_STATUS));
    rsel.sten = (bus_addr == AW'(OFF_STAT_EN));
    rsel.sgen = (bus_addr == AW'(OFF_SIG_EN));
    rsel.frc  = (bus_addr == AW'(OFF_FORCE));
    wsel.stat = bus_we & rsel.stat;
    wsel.sten = bus_we & rsel.sten;
    wsel.sgen = bus_we & rsel.sgen;
    wsel.frc  = bus_we & rsel.frc;
  end
endmodule

// File: rtl/ring_irq_status.sv
module ring_irq_status
  import ring_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_word,
  input  wr_sel_t       wsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] sten_q,
  output logic [DW-1:0] sgen_q
);
  localparam logic [DW-1:0] VMASK = DW'(valid_mask());

  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;
  logic [DW-1:0] frc_v;

  assign frc_v = wsel.frc ? wdata : '0;
  assign set_v = (evt_word | frc_v) & sten_q & VMASK;
  assign clr_v = wsel.stat ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      sten_q   <= '0;
      sgen_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (wsel.sten) sten_q <= wdata & VMASK;
      if (wsel.sgen) sgen_q <= wdata & VMASK;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_word & sten_q) != '0) |=> ((status_q & $past(evt_word & sten_q)) == $past(evt_word & sten_q)));
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(sten_q)) == '0));
  a_r4_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.stat |=> ((status_q & $past(wdata & ~evt_word & ~frc_v)) == '0));
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v & clr_v) != '0) |=> ((status_q & $past(set_v & clr_v)) == $past(set_v & clr_v)));
  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel.stat |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/ring_irq_unit.sv
module ring_irq_unit
  import ring_irq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam logic [DATA_W-1:0] VMASK = valid_mask();

  logic [DATA_W-1:0] evt_word;
  logic [DATA_W-1:0] status_q, sten_q, sgen_q;
  logic [DATA_W-1:0] pending;
  wr_sel_t           wsel, rsel;

  ring_irq_evt_map #(.NEVT(NUM_EVT), .DW(DATA_W)) u_map (
    .evt_i(evt_i), .evt_word(evt_word));

  ring_irq_decode #(.AW(AW)) u_dec (
    .bus_addr(bus_addr), .bus_we(bus_we), .wsel(wsel), .rsel(rsel));

  ring_irq_status #(.DW(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_word(evt_word), .wsel(wsel),
    .wdata(bus_wdata), .status_q(status_q), .sten_q(sten_q), .sgen_q(sgen_q));

  assign pending = status_q & sgen_q;
  assign irq_o   = |pending;

  always_comb begin
    bus_rdata = '0;
    if (rsel.stat) bus_rdata = status_q;
    if (rsel.sten) bus_rdata = sten_q;
    if (rsel.sgen) bus_rdata = sgen_q;
  end

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~VMASK) == '0);
  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_q != '0 && sgen_q != '0));
  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wsel.stat && !wsel.sgen) |=> irq_o);
endmodule

// File: tb/ring_irq_unit_tb.sv
module ring_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VM = 32'h0000_1EE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_st, m_en, m_sg;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_irq_unit dut_i (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  function automatic logic [31:0] pos_of(input logic [6:0] e);
    logic [31:0] w = '0;
    for (int k = 0; k < 7; k++) if (e[k]) w[k < 3 ? 5 + k : 6 + k] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string tag);
    chk(tag, {31'b0, irq_o}, {31'b0, |(m_st & m_sg)});
  endtask

  // One cycle: drive at negedge, return at next negedge with registers updated.
  task automatic cyc(input logic [6:0] e, input logic we, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] setw, clrw;
    evt_i = e; bus_we = we; bus_addr = a; bus_wdata = d;
    setw = (pos_of(e) | ((we && a == 8'h1C) ? d : 32'h0)) & m_en & VM;
    clrw = (we && a == 8'h10) ? d : 32'h0;
    @(negedge clk);
    m_st = (m_st & ~clrw) | setw;
    if (we && a == 8'h14) m_en = d & VM;
    if (we && a == 8'h18) m_sg = d & VM;
    evt_i = '0; bus_we = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_st = '0; m_en = '0; m_sg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 status", 8'h10, 32'h0);
    rd("R1 stat_en", 8'h14, 32'h0);
    rd("R1 sig_en", 8'h18, 32'h0);
    irq_chk("R1 irq");

    // R3 events with enable clear are dropped
    cyc(7'h7F, 1'b0, 8'h0, 32'h0);
    rd("R3 all disabled", 8'h10, 32'h0);

    // R9 / R8 mask readback with unused bits
    cyc('0, 1'b1, 8'h14, 32'hFFFF_FFFF);
    rd("R9 R8 stat_en readback", 8'h14, VM);
    cyc('0, 1'b1, 8'h18, 32'hA5A5_A5A5);
    rd("R9 R8 sig_en readback", 8'h18, 32'hA5A5_A5A5 & VM);

    // R2 / R6 exhaustive sweep of event patterns under two signal masks
    for (int s = 0; s < 2; s++) begin
      cyc('0, 1'b1, 8'h18, s == 0 ? 32'h0000_0C20 : 32'h0);
      for (int p = 0; p < 128; p++) begin
        cyc(7'(p), 1'b0, 8'h0, 32'h0);
        rd("R2 event map", 8'h10, pos_of(7'(p)));
        irq_chk("R6 irq level");
        cyc('0, 1'b0, 8'h0, 32'h0);
        irq_chk("R6 irq held");
        cyc('0, 1'b1, 8'h10, 32'hFFFF_FFFF);
        rd("R4 clear all", 8'h10, 32'h0);
      end
    end

    // R3 partial enable sweep
    cyc('0, 1'b1, 8'h14, 32'h0000_1520);
    for (int p = 0; p < 128; p++) begin
      cyc(7'(p), 1'b0, 8'h0, 32'h0);
      rd("R3 partial enable", 8'h10, pos_of(7'(p)) & 32'h0000_1520);
      cyc('0, 1'b1, 8'h10, 32'hFFFF_FFFF);
    end

    // R4 clears exactly the written bits
    cyc('0, 1'b1, 8'h14, VM);
    cyc(7'h7F, 1'b0, 8'h0, 32'h0);
    cyc('0, 1'b1, 8'h10, 32'h0000_0A40);
    rd("R4 partial clear", 8'h10, VM & ~32'h0000_0A40);

    // R5 event collides with clear
    cyc(7'h01, 1'b1, 8'h10, VM);
    rd("R5 set beats clear", 8'h10, 32'h0000_0020);

    // R10 clearing enable keeps latched bit
    cyc('0, 1'b1, 8'h14, 32'h0);
    rd("R10 status kept", 8'h10, 32'h0000_0020);
    cyc('0, 1'b1, 8'h18, 32'h0000_0020);
    irq_chk("R6 irq from kept bit");
    chk("R6 irq high", {31'b0, irq_o}, 32'h1);
    cyc('0, 1'b1, 8'h18, 32'h0);
    chk("R6 irq masked", {31'b0, irq_o}, 32'h0);

    // R7 force gated by enable, reads zero
    cyc('0, 1'b1, 8'h1C, VM);
    rd("R7 force gated", 8'h10, 32'h0000_0020);
    cyc('0, 1'b1, 8'h14, 32'h0000_1040);
    cyc('0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
    rd("R7 force sets", 8'h10, 32'h0000_1060);
    rd("R7 force reads zero", 8'h1C, 32'h0);

    // R8 other addresses
    cyc('0, 1'b1, 8'h20, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 8'h00, 32'hFFFF_FFFF);
    rd("R8 unmapped read", 8'h20, 32'h0);
    rd("R8 status untouched", 8'h10, 32'h0000_1060);
    rd("R8 stat_en untouched", 8'h14, 32'h0000_1040);
    rd("R8 sig_en untouched", 8'h18, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule